// File: doc/BRIEF.md
# Descending Sorter with Position Tracking

This block takes a vector of P unsigned fractional components and sorts them into descending order inside a small on-chip memory. It also builds a table that gives, for every original component, the slot that component occupies after the sort. A later stage uses that table to reorder rows of a switching pattern.

A one-cycle `start_i` pulse starts a run. The block then fetches the components one per cycle from an external source through an address it drives, with the data returned combinationally. It sorts them with repeated passes of adjacent compare-and-exchange steps until a pass makes no exchange. It then inverts its internal origin tags into the position table and pulses `done_o`. While idle, two independent asynchronous read ports give access to the sorted values and to the position table.

Top module: `desc_perm_sort`

## Requirements
- R1: While reset is held and in the first cycle after it, `done_o` is 0 and `src_addr_o` is 0.
- R2: The cycle after a `start_i` pulse is sampled in idle, the block reads source slots 0 to P-1 in ascending order, one slot per cycle. `src_data_i` must hold the value of slot `src_addr_o` in the same cycle.
- R3: After `done_o`, reading sorted slot j gives the j-th largest input, so slot j is always greater than or equal to slot j+1. The sorted values are a permutation of the inputs.
- R4: Two components are exchanged only when the earlier one is strictly less than the later one. Equal components keep their original relative order.
- R5: After `done_o`, reading address i of the position table gives the 0-based sorted slot now holding original component i.
- R6: Passes run over pairs (0,1) to (P-2,P-1) and repeat until a full pass makes no exchange. Each compared pair costs one cycle, and each exchange costs one more cycle. Take the edge that samples `start_i` as edge 1, and let S be the total number of sort cycles. Then `done_o` is high right after edge 2P+S+1.
- R7: `done_o` is high for exactly one cycle per run.
- R8: A `start_i` pulse that arrives while a run is in progress has no effect on the results or on the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle run request, accepted only when idle |
| done_o | output | 1 | One-cycle completion pulse |
| src_addr_o | output | $clog2(P) | Source component address |
| src_data_i | input | Q | Source component at `src_addr_o`, same cycle |
| val_raddr_i | input | $clog2(P) | Sorted value read address |
| val_rdata_o | output | Q | Sorted value at `val_raddr_i` |
| pos_raddr_i | input | $clog2(P) | Original component index for the position table |
| pos_rdata_o | output | $clog2(P) | Final sorted slot of that component |

## Verification
The sort is driven with several input patterns, each of which tells apart a different fault:
- Already-descending input gives the minimum of one clean pass, which exposes any spurious exchanges.
- Ascending input forces the maximum number of passes and exchanges, which stresses the pass-repeat decision and the completion time.
- All-equal vectors and alternating repeated values expose a non-strict comparison, because ties must not move and the position table must stay stable.
- Extremes at zero and at full scale expose comparator width errors.
- Random vectors, some drawn from a narrow range so that ties are common, cover mixed cases.
- A run that receives a second `start_i` while busy, with the source contents changed, shows whether a busy request is really ignored.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CMP,
    ST_SWP,
    ST_INV,
    ST_FIN
  } sort_state_e;
endpackage

// File: rtl/dps_ram.sv
module dps_ram #(
  parameter int W   = 8,
  parameter int D   = 5,
  parameter int NRD = 2,
  localparam int AW = (D > 1) ? $clog2(D) : 1
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [W-1:0]             wdata_i,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][W-1:0]    rdata_o
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rdata_o[r] = mem[raddr_i[r]];
  end
endmodule

// File: rtl/dps_ctrl.sv
module dps_ctrl
  import dps_pkg::*;
#(
  parameter int P = 5,
  parameter int Q = 9,
  localparam int IW = $clog2(P)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          done_o,
  output logic          busy_o,
  output logic [IW-1:0] src_addr_o,
  input  logic [Q-1:0]  src_data_i,
  output logic [IW-1:0] rd0_addr_o,
  output logic [IW-1:0] rd1_addr_o,
  input  logic [Q-1:0]  val_rd0_i,
  input  logic [Q-1:0]  val_rd1_i,
  input  logic [IW-1:0] tag_rd0_i,
  input  logic [IW-1:0] tag_rd1_i,
  output logic          val_we_o,
  output logic [IW-1:0] val_waddr_o,
  output logic [Q-1:0]  val_wdata_o,
  output logic          tag_we_o,
  output logic [IW-1:0] tag_waddr_o,
  output logic [IW-1:0] tag_wdata_o,
  output logic          pos_we_o,
  output logic [IW-1:0] pos_waddr_o,
  output logic [IW-1:0] pos_wdata_o
);
  localparam logic [IW-1:0] LAST_IDX  = IW'(P - 1);
  localparam logic [IW-1:0] LAST_PAIR = IW'(P - 2);

  sort_state_e   state_q;
  logic [IW-1:0] idx_q;
  logic          swapped_q;
  logic [Q-1:0]  aux_val_q;
  logic [IW-1:0] aux_tag_q;

  logic [IW-1:0] idx_nx;
  logic          lt;
  logic          at_last;
  logic          at_last_pair;

  assign idx_nx       = idx_q + IW'(1);
  assign lt           = val_rd0_i < val_rd1_i;  // strict: ties stay put
  assign at_last      = idx_q == LAST_IDX;
  assign at_last_pair = idx_q == LAST_PAIR;

  assign src_addr_o = idx_q;
  assign rd0_addr_o = idx_q;
  assign rd1_addr_o = idx_nx;
  assign done_o     = state_q == ST_FIN;
  assign busy_o     = state_q != ST_IDLE;

  always_comb begin
    val_we_o    = 1'b0;
    val_waddr_o = idx_q;
    val_wdata_o = src_data_i;
    tag_we_o    = 1'b0;
    tag_waddr_o = idx_q;
    tag_wdata_o = idx_q;
    pos_we_o    = 1'b0;
    pos_waddr_o = tag_rd0_i;
    pos_wdata_o = idx_q;
    unique case (state_q)
      ST_LOAD: begin
        val_we_o = 1'b1;
        tag_we_o = 1'b1;
      end
      ST_CMP: begin
        if (lt) begin
          val_we_o    = 1'b1;
          val_wdata_o = val_rd1_i;
          tag_we_o    = 1'b1;
          tag_wdata_o = tag_rd1_i;
        end
      end
      ST_SWP: begin
        val_we_o    = 1'b1;
        val_waddr_o = idx_nx;
        val_wdata_o = aux_val_q;
        tag_we_o    = 1'b1;
        tag_waddr_o = idx_nx;
        tag_wdata_o = aux_tag_q;
      end
      ST_INV: pos_we_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      swapped_q <= 1'b0;
      aux_val_q <= '0;
      aux_tag_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_LOAD;
            idx_q   <= '0;
          end
        end
        ST_LOAD: begin
          if (at_last) begin
            state_q   <= ST_CMP;
            idx_q     <= '0;
            swapped_q <= 1'b0;
          end else begin
            idx_q <= idx_nx;
          end
        end
        ST_CMP: begin
          if (lt) begin
            aux_val_q <= val_rd0_i;
            aux_tag_q <= tag_rd0_i;
            swapped_q <= 1'b1;
            state_q   <= ST_SWP;
          end else if (at_last_pair) begin
            idx_q     <= '0;
            swapped_q <= 1'b0;
            if (!swapped_q) state_q <= ST_INV;
          end else begin
            idx_q <= idx_nx;
          end
        end
        ST_SWP: begin
          state_q <= ST_CMP;
          if (at_last_pair) begin
            idx_q     <= '0;
            swapped_q <= 1'b0;
          end else begin
            idx_q <= idx_nx;
          end
        end
        ST_INV: begin
          if (at_last) begin
            state_q <= ST_FIN;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_nx;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/desc_perm_sort.sv
module desc_perm_sort #(
  parameter int P = 5,
  parameter int Q = 9,
  localparam int IW = $clog2(P)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          done_o,
  output logic [IW-1:0] src_addr_o,
  input  logic [Q-1:0]  src_data_i,
  input  logic [IW-1:0] val_raddr_i,
  output logic [Q-1:0]  val_rdata_o,
  input  logic [IW-1:0] pos_raddr_i,
  output logic [IW-1:0] pos_rdata_o
);
  logic                busy;
  logic [IW-1:0]       rd0_addr, rd1_addr, val_ra1;
  logic [1:0][Q-1:0]   val_rdata;
  logic [1:0][IW-1:0]  tag_rdata;
  logic                val_we, tag_we, pos_we;
  logic [IW-1:0]       val_waddr, tag_waddr, tag_wdata, pos_waddr, pos_wdata;
  logic [Q-1:0]        val_wdata;

  // second value port is shared: sort pair when busy, external when idle
  assign val_ra1     = busy ? rd1_addr : val_raddr_i;
  assign val_rdata_o = val_rdata[1];

  dps_ctrl #(.P(P), .Q(Q)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .done_o      (done_o),
    .busy_o      (busy),
    .src_addr_o  (src_addr_o),
    .src_data_i  (src_data_i),
    .rd0_addr_o  (rd0_addr),
    .rd1_addr_o  (rd1_addr),
    .val_rd0_i   (val_rdata[0]),
    .val_rd1_i   (val_rdata[1]),
    .tag_rd0_i   (tag_rdata[0]),
    .tag_rd1_i   (tag_rdata[1]),
    .val_we_o    (val_we),
    .val_waddr_o (val_waddr),
    .val_wdata_o (val_wdata),
    .tag_we_o    (tag_we),
    .tag_waddr_o (tag_waddr),
    .tag_wdata_o (tag_wdata),
    .pos_we_o    (pos_we),
    .pos_waddr_o (pos_waddr),
    .pos_wdata_o (pos_wdata)
  );

  dps_ram #(.W(Q), .D(P), .NRD(2)) u_val_ram (
    .clk_i   (clk_i),
    .we_i    (val_we),
    .waddr_i (val_waddr),
    .wdata_i (val_wdata),
    .raddr_i ({val_ra1, rd0_addr}),
    .rdata_o (val_rdata)
  );

  dps_ram #(.W(IW), .D(P), .NRD(2)) u_tag_ram (
    .clk_i   (clk_i),
    .we_i    (tag_we),
    .waddr_i (tag_waddr),
    .wdata_i (tag_wdata),
    .raddr_i ({rd1_addr, rd0_addr}),
    .rdata_o (tag_rdata)
  );

  dps_ram #(.W(IW), .D(P), .NRD(1)) u_pos_ram (
    .clk_i   (clk_i),
    .we_i    (pos_we),
    .waddr_i (pos_waddr),
    .wdata_i (pos_wdata),
    .raddr_i (pos_raddr_i),
    .rdata_o (pos_rdata_o)
  );
endmodule

// File: rtl/dps_chk.sv
module dps_chk #(
  parameter int P = 5,
  parameter int IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          done_o,
  input logic          busy,
  input logic [IW-1:0] src_addr_o,
  input logic          pos_we,
  input logic [IW-1:0] pos_waddr,
  input logic [IW-1:0] pos_wdata
);
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done_o) |=> busy);

  // R8
  busy_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(start_i));

  // R2
  load_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> (src_addr_o == '0));

  // R6
  done_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy));

  // R5
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_we |-> (pos_wdata < IW'(P) && pos_waddr < IW'(P)));
endmodule

bind desc_perm_sort dps_chk #(.P(P), .IW(IW)) u_dps_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .done_o     (done_o),
  .busy       (busy),
  .src_addr_o (src_addr_o),
  .pos_we     (pos_we),
  .pos_waddr  (pos_waddr),
  .pos_wdata  (pos_wdata)
);

// File: tb/desc_perm_sort_bench.sv
module desc_perm_sort_bench;
  localparam int P = 5;
  localparam int Q = 9;
  localparam int IW = $clog2(P);
  localparam time CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          done;
  logic [IW-1:0] src_addr;
  logic [Q-1:0]  src_data;
  logic [IW-1:0] val_raddr = '0;
  logic [Q-1:0]  val_rdata;
  logic [IW-1:0] pos_raddr = '0;
  logic [IW-1:0] pos_rdata;

  logic [Q-1:0] src_mem [P];
  int exp_val [P];
  int exp_pos [P];
  int exp_cyc;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  assign src_data = src_mem[src_addr];

  always #(CLK_PERIOD / 2) clk = ~clk;

  desc_perm_sort #(.P(P), .Q(Q)) u_desc_perm_sort (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .done_o      (done),
    .src_addr_o  (src_addr),
    .src_data_i  (src_data),
    .val_raddr_i (val_raddr),
    .val_rdata_o (val_rdata),
    .pos_raddr_i (pos_raddr),
    .pos_rdata_o (pos_rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected results from the requirements: strict descending exchange passes
  task automatic model();
    int v [P];
    int t [P];
    int s;
    bit sw;
    for (int i = 0; i < P; i++) begin
      v[i] = int'(src_mem[i]);
      t[i] = i;
    end
    s = 0;
    do begin
      sw = 0;
      for (int k = 0; k < P - 1; k++) begin
        s++;
        if (v[k] < v[k+1]) begin
          int tv, tt;
          tv = v[k]; v[k] = v[k+1]; v[k+1] = tv;
          tt = t[k]; t[k] = t[k+1]; t[k+1] = tt;
          s++;
          sw = 1;
        end
      end
    end while (sw);
    for (int k = 0; k < P; k++) begin
      exp_val[k] = v[k];
      exp_pos[t[k]] = k;
    end
    exp_cyc = 2 * P + s + 1;
  endtask

  task automatic run(input bit inject);
    int n;
    model();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = 1'b0;
      if (inject && n == 8 && !done) begin
        for (int i = 0; i < P; i++) src_mem[i] = Q'(i * 37);
        start = 1'b1;
      end
    end
    start = 1'b0;
    check("R6 completion edge", n, exp_cyc);
    @(negedge clk);
    check("R7 done width", int'(done), 0);
    for (int j = 0; j < P; j++) begin
      val_raddr = IW'(j);
      pos_raddr = IW'(j);
      #1;
      check(inject ? "R8 R2 R3 value" : "R2 R3 value", int'(val_rdata), exp_val[j]);
      check(inject ? "R8 R5 R4 pos" : "R5 R4 pos", int'(pos_rdata), exp_pos[j]);
    end
    for (int j = 0; j < P - 1; j++) begin
      int a;
      val_raddr = IW'(j);
      #1;
      a = int'(val_rdata);
      val_raddr = IW'(j + 1);
      #1;
      check("R3 descending", int'(a >= int'(val_rdata)), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < P; i++) src_mem[i] = '0;
    #(CLK_PERIOD * 3);
    // R1
    check("R1 done in reset", int'(done), 0);
    check("R1 addr in reset", int'(src_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 addr after reset", int'(src_addr), 0);

    // ascending input: worst case exchanges
    for (int i = 0; i < P; i++) src_mem[i] = Q'(i * 50 + 3);
    run(0);
    // already descending: single clean pass
    for (int i = 0; i < P; i++) src_mem[i] = Q'(500 - i * 60);
    run(0);
    // all equal: R4 nothing moves
    for (int i = 0; i < P; i++) src_mem[i] = Q'(77);
    run(0);
    // alternating ties
    for (int i = 0; i < P; i++) src_mem[i] = (i % 2 == 0) ? Q'(7) : Q'(300);
    run(0);
    // extremes
    src_mem[0] = '0; src_mem[1] = '1; src_mem[2] = '0; src_mem[3] = '1; src_mem[4] = Q'(1);
    run(0);
    // R8: start while busy with changed source
    for (int i = 0; i < P; i++) src_mem[i] = Q'(400 - i * 90 + (i == 3 ? 250 : 0));
    run(1);
    // random, with narrow ranges for frequent ties
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < P; i++)
        src_mem[i] = (r % 2 == 0) ? Q'($urandom % 4) : Q'($urandom);
      run(0);
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule